// File: doc/BRIEF.md
# 16-bit Timer/Counter with Capture and Compare

This peripheral holds a 16-bit counter that advances on a selectable count clock: stopped, a one-cycle tick from an external prescaler, or the rising or falling edge of a synchronized external pin. The counter runs either up-only, wrapping from TOP to zero, or up-down, turning at TOP and at zero. TOP is either a fixed parameter value or the value held in the capture register. Two compare channels watch the counter. Each has a buffered compare value that only takes effect at a defined point in the count cycle. On a match, a channel sets its flag and applies a chosen action to its waveform output.

The capture channel takes its trigger from a pin or from a comparator output. The trigger can be filtered for noise and is detected on a chosen edge. A capture event latches the counter into the capture register. Software reaches every register through an 8-bit bus, and the 16-bit registers go through a shared temporary byte so that all 16 bits are read or written at once. Four event flags sit behind a mask register and drive four interrupt request lines.

Register map (byte offsets on `bus_addr`):

- 0, mode control. Bits [1:0] are the action for channel A and bits [3:2] the action for channel B (0 none, 1 toggle, 2 drive low, 3 drive high). Bit 4 selects up-down counting. Bit 5 takes TOP from the capture register.
- 1, source control. Bits [2:0] are the count-clock select. Bit 3 selects the rising capture edge (0 selects the falling edge). Bit 4 enables the noise filter. Bit 5 takes the capture source from the comparator.
- 2/3, counter (low/high byte).
- 4/5, compare A (low/high byte).
- 6/7, compare B (low/high byte).
- 8/9, capture (low/high byte).
- 10, flags.
- 11, mask.

Top module: `cap_timer16`

## Requirements
- R1: After reset, the following all read as zero: the counter, both compare buffers, the capture register, both control registers, the flags and the mask. Both waveform outputs and all `irq` lines are low.
- R2: Reading a low byte (offset 2, 4, 6 or 8) latches that register's high byte into a temporary byte, and reading the high byte (offset+1) returns the temporary byte. Writing a high byte only loads the temporary byte. Writing the low byte then commits {temporary, data} in one cycle. A high-byte write alone leaves the register unchanged.
- R3: Count-clock select (source control bits [2:0]): 0 and 4 to 7 hold the counter, 1 counts each cycle in which `presc_tick` is high, 2 counts rising edges of `ext_clk_pin`, and 3 counts falling edges of `ext_clk_pin`.
- R4: Up-only mode (mode bit 4 = 0): on a count at TOP, the counter goes to 0 and sets the overflow flag (flag bit 0). Otherwise it increments. TOP is FIXED_TOP (default 0xFFFF) when mode bit 5 = 0 and the capture register when it is 1.
- R5: Up-down mode (mode bit 4 = 1): after a counter write, the direction is up. A count at TOP turns the direction to down and decrements. A count at 0 while going down turns the direction to up, increments and sets the overflow flag.
- R6: A compare write goes to a buffer. The active compare value takes the buffer on the count at TOP: in up-only mode, the wrap to zero, and in up-down mode, only while counting up.
- R7: A count in which the counter equals a channel's active compare value sets that channel's flag (A bit 1, B bit 2) and applies the channel's action to its waveform output.
- R8: A capture event copies the counter into the capture register and sets flag bit 3. The capture source is `cap_pin` (source bit 5 = 0) or `cmp_in` (= 1). The event edge is rising when source bit 3 = 1 and falling when it is 0, and the other edge is ignored. Capture is ignored entirely while mode bit 5 = 1.
- R9: With the noise filter on (source bit 4), a trigger level held for fewer than FILT_LEN (4) clocks is ignored. The filter adds exactly FILT_LEN clocks of capture latency.
- R10: Writing a 1 to a flag bit clears it, and writing a 0 leaves it unchanged. `irq[i]` is high exactly when flag i and mask bit i are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (latches temporary byte) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| presc_tick | input | 1 | Prescaled count tick |
| ext_clk_pin | input | 1 | External count clock pin |
| cap_pin | input | 1 | Capture trigger pin |
| cmp_in | input | 1 | Comparator output capture source |
| wave_a | output | 1 | Channel A waveform output |
| wave_b | output | 1 | Channel B waveform output |
| irq | output | 4 | Masked requests: overflow, A, B, capture |

## Verification
The hardest situation to reach from the ports is a compare match that happens while the buffer holds a new value that is not yet active. The bench parks the counter just short of the new compare value and before the update point. It then ticks through that value and shows that no match occurs, and shows that the match appears only after the wrap, or after the turn at TOP in up-down mode. The noise filter is exercised in a similar way. The bench sweeps the trigger pulse width across the acceptance threshold and measures the flag latency with the filter on and off, so that the four-clock difference is checked without depending on the synchronizer depth.

// File: rtl/cap_timer16_pkg.sv
package cap_timer16_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } wave_act_e;

  localparam logic [3:0] ADDR_CTRL0 = 4'd0;
  localparam logic [3:0] ADDR_CTRL1 = 4'd1;
  localparam logic [3:0] ADDR_CNT   = 4'd2;
  localparam logic [3:0] ADDR_CMPA  = 4'd4;
  localparam logic [3:0] ADDR_CMPB  = 4'd6;
  localparam logic [3:0] ADDR_CAP   = 4'd8;
  localparam logic [3:0] ADDR_FLAG  = 4'd10;
  localparam logic [3:0] ADDR_MASK  = 4'd11;

  localparam logic [2:0] CS_TICK = 3'd1;
  localparam logic [2:0] CS_RISE = 3'd2;
  localparam logic [2:0] CS_FALL = 3'd3;

  localparam int NUM_CH    = 2;
  localparam int NUM_FLAGS = 4;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic filt_en,
  output logic rise,
  output logic fall
);
  localparam int SW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [SW-1:0] LAST = SW'(FILT_LEN - 1);

  logic sync1, sync2, filt, prev;
  logic filt_d, lvl;
  logic [SW-1:0] stab, stab_d;

  always_comb begin
    filt_d = filt;
    stab_d = '0;
    if (sync2 != filt) begin
      if (stab == LAST) begin
        filt_d = sync2;
      end else begin
        stab_d = stab + 1'b1;
      end
    end
    lvl  = filt_en ? filt : sync2;
    rise = lvl & ~prev;
    fall = ~lvl & prev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      filt  <= 1'b0;
      prev  <= 1'b0;
      stab  <= '0;
    end else begin
      sync1 <= din;
      sync2 <= sync1;
      filt  <= filt_d;
      prev  <= lvl;
      stab  <= stab_d;
    end
  end

  assert_filt_settled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> $past(stab) == LAST);
  assert_filt_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync2 == filt) |=> $stable(filt));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         up_down,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         ovf_ev,
  output logic         upd_ev
);
  logic         dir_up, dir_d;
  logic [W-1:0] cnt_d;
  logic         at_top, at_bot;

  always_comb begin
    at_top = (cnt == top);
    at_bot = (cnt == '0);
    cnt_d  = cnt;
    dir_d  = dir_up;
    ovf_ev = 1'b0;
    upd_ev = 1'b0;
    if (ld) begin
      cnt_d = ld_val;
      dir_d = 1'b1;
    end else if (tick) begin
      if (!up_down) begin
        dir_d  = 1'b1;
        ovf_ev = at_top;
        upd_ev = at_top;
        cnt_d  = at_top ? '0 : cnt + 1'b1;
      end else if (dir_up) begin
        if (at_top) begin
          upd_ev = 1'b1;
          dir_d  = 1'b0;
          cnt_d  = at_bot ? cnt : cnt - 1'b1;
        end else begin
          cnt_d = cnt + 1'b1;
        end
      end else begin
        if (at_bot) begin
          ovf_ev = 1'b1;
          dir_d  = 1'b1;
          cnt_d  = at_top ? cnt : cnt + 1'b1;
        end else begin
          cnt_d = cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else begin
      cnt    <= cnt_d;
      dir_up <= dir_d;
    end
  end

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld) |=> $stable(cnt));
  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && !up_down && cnt == top) |=> (cnt == '0));
  assert_turn_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && up_down && dir_up && cnt == top && cnt != '0) |=> !dir_up);
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan import cap_timer16_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         upd,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] buf_val,
  input  wave_act_e    act,
  output logic         match,
  output logic         wave
);
  logic [W-1:0] active, active_d;
  logic         wave_d;

  always_comb begin
    match    = tick & (cnt == active);
    active_d = upd ? buf_val : active;
    wave_d   = wave;
    if (match) begin
      case (act)
        ACT_TOGGLE: wave_d = ~wave;
        ACT_CLEAR:  wave_d = 1'b0;
        ACT_SET:    wave_d = 1'b1;
        default:    wave_d = wave;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
      wave   <= 1'b0;
    end else begin
      active <= active_d;
      wave   <= wave_d;
    end
  end

  assert_buffer_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(active));
  assert_set_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (match && act == ACT_SET) |=> wave);
  assert_clear_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (match && act == ACT_CLEAR) |=> !wave);
endmodule

// File: rtl/cap_timer16.sv
module cap_timer16 import cap_timer16_pkg::*; #(
  parameter int BUS_W = 8,
  parameter int FILT_LEN = 4,
  parameter logic [2*BUS_W-1:0] FIXED_TOP = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             presc_tick,
  input  logic             ext_clk_pin,
  input  logic             cap_pin,
  input  logic             cmp_in,
  output logic             wave_a,
  output logic             wave_b,
  output logic [3:0]       irq
);
  localparam int CW = 2 * BUS_W;

  logic [1:0] rst_pipe;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  logic [BUS_W-1:0] ctrl0, ctrl1, tmp;
  logic [BUS_W-1:0] ctrl0_d, ctrl1_d, tmp_d;
  logic [NUM_CH-1:0][CW-1:0] cmp_buf, cmp_buf_d;
  logic [CW-1:0] cap_reg, cap_reg_d, cnt, top_val;
  logic [NUM_FLAGS-1:0] flags, flags_d, mask, mask_d;
  logic tick, tick_q, cnt_ld, ovf_ev, upd_ev, cap_ev;
  logic ext_rise, ext_fall, cap_rise, cap_fall, cap_src;
  logic [NUM_CH-1:0] match, wave;

  tmr_edge #(.FILT_LEN(FILT_LEN)) u_ext_edge (
    .clk(clk), .rst_n(rst_i), .din(ext_clk_pin), .filt_en(1'b0),
    .rise(ext_rise), .fall(ext_fall));

  tmr_edge #(.FILT_LEN(FILT_LEN)) u_cap_edge (
    .clk(clk), .rst_n(rst_i), .din(cap_src), .filt_en(ctrl1[4]),
    .rise(cap_rise), .fall(cap_fall));

  tmr_counter #(.W(CW)) u_counter (
    .clk(clk), .rst_n(rst_i), .tick(tick), .ld(cnt_ld),
    .ld_val({tmp, bus_wdata}), .up_down(ctrl0[4]), .top(top_val),
    .cnt(cnt), .ovf_ev(ovf_ev), .upd_ev(upd_ev));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_cmp_chan #(.W(CW)) u_chan (
      .clk(clk), .rst_n(rst_i), .tick(tick_q), .upd(upd_ev), .cnt(cnt),
      .buf_val(cmp_buf[g]), .act(wave_act_e'(ctrl0[2*g +: 2])),
      .match(match[g]), .wave(wave[g]));
  end

  assign wave_a = wave[0];
  assign wave_b = wave[1];

  always_comb begin
    case (ctrl1[2:0])
      CS_TICK: tick = presc_tick;
      CS_RISE: tick = ext_rise;
      CS_FALL: tick = ext_fall;
      default: tick = 1'b0;
    endcase
    cnt_ld  = bus_wr && (bus_addr == ADDR_CNT);
    tick_q  = tick & ~cnt_ld;
    top_val = ctrl0[5] ? cap_reg : FIXED_TOP;
    cap_src = ctrl1[5] ? cmp_in : cap_pin;
    cap_ev  = ~ctrl0[5] & (ctrl1[3] ? cap_rise : cap_fall);
  end

  always_comb begin
    ctrl0_d   = ctrl0;
    ctrl1_d   = ctrl1;
    tmp_d     = tmp;
    cmp_buf_d = cmp_buf;
    cap_reg_d = cap_ev ? cnt : cap_reg;
    mask_d    = mask;
    flags_d   = flags;
    if (bus_rd) begin
      case (bus_addr)
        ADDR_CNT:  tmp_d = cnt[CW-1:BUS_W];
        ADDR_CMPA: tmp_d = cmp_buf[0][CW-1:BUS_W];
        ADDR_CMPB: tmp_d = cmp_buf[1][CW-1:BUS_W];
        ADDR_CAP:  tmp_d = cap_reg[CW-1:BUS_W];
        default:   tmp_d = tmp;
      endcase
    end
    if (bus_wr) begin
      case (bus_addr)
        ADDR_CTRL0: ctrl0_d = bus_wdata;
        ADDR_CTRL1: ctrl1_d = bus_wdata;
        ADDR_CMPA:  cmp_buf_d[0] = {tmp, bus_wdata};
        ADDR_CMPB:  cmp_buf_d[1] = {tmp, bus_wdata};
        ADDR_CAP:   cap_reg_d = {tmp, bus_wdata};
        ADDR_FLAG:  flags_d = flags & ~bus_wdata[NUM_FLAGS-1:0];
        ADDR_MASK:  mask_d = bus_wdata[NUM_FLAGS-1:0];
        ADDR_CNT + 4'd1, ADDR_CMPA + 4'd1, ADDR_CMPB + 4'd1, ADDR_CAP + 4'd1:
                    tmp_d = bus_wdata;
        default:    ;
      endcase
    end
    flags_d = flags_d | {cap_ev, match[1], match[0], ovf_ev};
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL0: bus_rdata = ctrl0;
      ADDR_CTRL1: bus_rdata = ctrl1;
      ADDR_CNT:   bus_rdata = cnt[BUS_W-1:0];
      ADDR_CMPA:  bus_rdata = cmp_buf[0][BUS_W-1:0];
      ADDR_CMPB:  bus_rdata = cmp_buf[1][BUS_W-1:0];
      ADDR_CAP:   bus_rdata = cap_reg[BUS_W-1:0];
      ADDR_FLAG:  bus_rdata = BUS_W'(flags);
      ADDR_MASK:  bus_rdata = BUS_W'(mask);
      ADDR_CNT + 4'd1, ADDR_CMPA + 4'd1, ADDR_CMPB + 4'd1, ADDR_CAP + 4'd1:
                  bus_rdata = tmp;
      default:    bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl0   <= '0;
      ctrl1   <= '0;
      tmp     <= '0;
      cmp_buf <= '0;
      cap_reg <= '0;
      flags   <= '0;
      mask    <= '0;
      irq     <= '0;
    end else begin
      ctrl0   <= ctrl0_d;
      ctrl1   <= ctrl1_d;
      tmp     <= tmp_d;
      cmp_buf <= cmp_buf_d;
      cap_reg <= cap_reg_d;
      flags   <= flags_d;
      mask    <= mask_d;
      irq     <= flags_d & mask_d;
    end
  end

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_wr && bus_addr == ADDR_FLAG && bus_wdata[0] && !ovf_ev) |=> !flags[0]);
  assert_cap_blocked_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (ctrl0[5] && !(bus_wr && bus_addr == ADDR_CAP)) |=> $stable(cap_reg));
  assert_high_write_only_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_wr && bus_addr == ADDR_CMPA + 4'd1) |=> $stable(cmp_buf[0]));
endmodule

// File: tb/cap_timer16_tb_top.sv
module cap_timer16_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, bus_wr, bus_rd, presc_tick, ext_clk_pin, cap_pin, cmp_in;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic wave_a, wave_b;
  logic [3:0] irq;

  cap_timer16 dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .presc_tick(presc_tick), .ext_clk_pin(ext_clk_pin), .cap_pin(cap_pin),
    .cmp_in(cmp_in), .wave_a(wave_a), .wave_b(wave_b), .irq(irq));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wr(4'(a + 1), v[15:8]);
    wr(a, v[7:0]);
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(4'(a + 1), hi);
    v = {hi, lo};
  endtask

  task automatic tick_n(input int n);
    if (n > 0) begin
      @(negedge clk);
      presc_tick = 1'b1;
      repeat (n) @(negedge clk);
      presc_tick = 1'b0;
    end
  endtask

  task automatic pin_pulse(input int w);
    @(negedge clk);
    cap_pin = 1'b1;
    repeat (w) @(negedge clk);
    cap_pin = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic flag_latency(input logic [7:0] src, output int lat);
    wr(4'd1, src);
    idle(10);
    wr(4'd10, 8'h0F);
    @(negedge clk);
    cap_pin = 1'b1;
    lat = 0;
    while (!irq[3] && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    cap_pin = 1'b0;
    idle(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0] b;
    int lat_off, lat_on;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    presc_tick = 1'b0; ext_clk_pin = 1'b0; cap_pin = 1'b0; cmp_in = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd16(4'd2, v); check("R1 counter", v, 0);
    rd16(4'd4, v); check("R1 compare A", v, 0);
    rd16(4'd6, v); check("R1 compare B", v, 0);
    rd16(4'd8, v); check("R1 capture", v, 0);
    rd(4'd0, b); check("R1 mode ctrl", b, 0);
    rd(4'd1, b); check("R1 source ctrl", b, 0);
    rd(4'd10, b); check("R1 flags", b, 0);
    rd(4'd11, b); check("R1 mask", b, 0);
    check("R1 waves", {wave_b, wave_a}, 0);
    check("R1 irq", irq, 0);

    // R2 16-bit access through the temporary byte
    wr16(4'd2, 16'h1234); rd16(4'd2, v); check("R2 counter write", v, 16'h1234);
    wr(4'd3, 8'h55); rd16(4'd2, v); check("R2 high byte alone", v, 16'h1234);
    wr16(4'd2, 16'hBEEF); rd16(4'd2, v); check("R2 counter rewrite", v, 16'hBEEF);
    wr16(4'd4, 16'hA5C3); rd16(4'd4, v); check("R2 compare A buffer", v, 16'hA5C3);
    wr(4'd5, 8'h11); rd16(4'd4, v); check("R2 compare high alone", v, 16'hA5C3);
    wr16(4'd4, 16'h0000);

    // R3 count-clock select sweep
    for (int sel = 0; sel < 5; sel++) begin
      int exp_d;
      wr(4'd0, 8'h00);
      wr(4'd1, 8'(sel));
      wr16(4'd2, 16'd100);
      for (int i = 0; i < 5; i++) begin
        @(negedge clk); presc_tick = 1'b1;
        @(negedge clk); presc_tick = 1'b0;
      end
      for (int i = 0; i < 3; i++) begin
        @(negedge clk); ext_clk_pin = 1'b1; idle(3);
        ext_clk_pin = 1'b0; idle(3);
      end
      idle(6);
      wr(4'd1, 8'h00);
      rd16(4'd2, v);
      exp_d = (sel == 1) ? 5 : (sel == 2 || sel == 3) ? 3 : 0;
      check($sformatf("R3 select %0d", sel), v, 100 + exp_d);
    end

    // R4 fixed TOP wrap
    wr(4'd1, 8'h01);
    wr16(4'd2, 16'hFFFD); wr(4'd10, 8'h0F);
    tick_n(3);
    rd16(4'd2, v); check("R4 fixed top wrap", v, 0);
    rd(4'd10, b); check("R4 fixed top overflow", b & 1, 1);

    // R4 up-only and R5 up-down sweeps with TOP from register
    for (int t = 1; t <= 5; t++) begin
      for (int k = 0; k < 3; k++) begin
        int n;
        n = (k == 0) ? t : (k == 1) ? t + 1 : 2 * t + 3;
        wr(4'd0, 8'h20); wr16(4'd8, 16'(t));
        wr16(4'd2, 16'd0); wr(4'd10, 8'h0F);
        tick_n(n);
        rd16(4'd2, v); check($sformatf("R4 top %0d ticks %0d count", t, n), v, n % (t + 1));
        rd(4'd10, b); check($sformatf("R4 top %0d ticks %0d ovf", t, n), b & 1, (n > t) ? 1 : 0);
      end
      for (int k = 0; k < 4; k++) begin
        int n, p;
        n = (k == 0) ? t : (k == 1) ? t + 2 : (k == 2) ? 2 * t : 2 * t + 1;
        p = n % (2 * t);
        wr(4'd0, 8'h30); wr16(4'd8, 16'(t));
        wr16(4'd2, 16'd0); wr(4'd10, 8'h0F);
        tick_n(n);
        rd16(4'd2, v); check($sformatf("R5 top %0d ticks %0d count", t, n), v, (p <= t) ? p : 2 * t - p);
        rd(4'd10, b); check($sformatf("R5 top %0d ticks %0d ovf", t, n), b & 1, (n > 2 * t) ? 1 : 0);
      end
    end

    // R6 buffered compare in up-only mode, TOP = 9
    wr(4'd0, 8'h21); wr16(4'd8, 16'd9);
    wr16(4'd2, 16'd2); wr16(4'd4, 16'd5); wr(4'd10, 8'h0F);
    tick_n(4);
    rd(4'd10, b); check("R6 buffer not yet active", (b >> 1) & 1, 0);
    tick_n(4); wr(4'd10, 8'h0F);
    tick_n(5);
    rd(4'd10, b); check("R6 active before match", (b >> 1) & 1, 0);
    tick_n(1);
    rd(4'd10, b); check("R7 match flag A", (b >> 1) & 1, 1);
    check("R7 toggle wave A", wave_a, 1);

    // R7 action sweep: set, none, toggle, toggle, clear
    begin
      int modes [5] = '{3, 0, 1, 1, 2};
      int waves [5] = '{1, 1, 0, 1, 0};
      for (int i = 0; i < 5; i++) begin
        wr(4'd0, 8'(8'h20 | modes[i])); wr(4'd10, 8'h0F);
        tick_n(10);
        rd(4'd10, b); check($sformatf("R7 action %0d flag", modes[i]), (b >> 1) & 1, 1);
        check($sformatf("R7 action %0d wave A", modes[i]), wave_a, waves[i]);
      end
    end

    // R6 buffered compare in up-down mode: update at TOP while rising
    wr(4'd0, 8'h3C);
    wr16(4'd2, 16'd1); wr16(4'd6, 16'd3); wr(4'd10, 8'h0F);
    tick_n(8);
    rd(4'd10, b); check("R6 up-down before TOP", (b >> 2) & 1, 0);
    tick_n(6);
    rd(4'd10, b); check("R6 up-down after TOP", (b >> 2) & 1, 0);
    tick_n(1);
    rd(4'd10, b); check("R7 match flag B falling", (b >> 2) & 1, 1);
    check("R7 set wave B", wave_b, 1);

    // R10 flag clearing and masking
    wr(4'd0, 8'h20); wr16(4'd2, 16'd0); wr(4'd10, 8'h0F);
    tick_n(10);
    rd(4'd10, b); check("R10 three flags set", b, 7);
    wr(4'd10, 8'h02); rd(4'd10, b); check("R10 write one clears", b, 5);
    wr(4'd10, 8'h00); rd(4'd10, b); check("R10 write zero keeps", b, 5);
    for (int m = 0; m < 16; m++) begin
      wr(4'd11, 8'(m));
      check($sformatf("R10 irq mask %0h", m), irq, 5 & m);
    end
    wr(4'd11, 8'h00);

    // R8 capture sources and edges, counter stopped
    wr(4'd0, 8'h00); wr(4'd1, 8'h08);
    wr16(4'd2, 16'h1357); wr(4'd10, 8'h0F);
    @(negedge clk); cap_pin = 1'b1; idle(8);
    rd16(4'd8, v); check("R8 rising capture value", v, 16'h1357);
    rd(4'd10, b); check("R8 rising capture flag", (b >> 3) & 1, 1);
    wr16(4'd2, 16'h2468); wr(4'd10, 8'h0F);
    @(negedge clk); cap_pin = 1'b0; idle(8);
    rd16(4'd8, v); check("R8 falling ignored value", v, 16'h1357);
    rd(4'd10, b); check("R8 falling ignored flag", (b >> 3) & 1, 0);
    wr(4'd1, 8'h00);
    @(negedge clk); cap_pin = 1'b1; idle(8);
    rd16(4'd8, v); check("R8 rising ignored in falling mode", v, 16'h1357);
    @(negedge clk); cap_pin = 1'b0; idle(8);
    rd16(4'd8, v); check("R8 falling capture value", v, 16'h2468);
    wr(4'd1, 8'h28); wr16(4'd2, 16'h0ABC); wr(4'd10, 8'h0F);
    pin_pulse(6); idle(8);
    rd(4'd10, b); check("R8 pin ignored with comparator source", (b >> 3) & 1, 0);
    @(negedge clk); cmp_in = 1'b1; idle(8);
    rd16(4'd8, v); check("R8 comparator capture value", v, 16'h0ABC);
    @(negedge clk); cmp_in = 1'b0; idle(8);
    wr(4'd1, 8'h08); wr(4'd0, 8'h20);
    wr16(4'd2, 16'h0777); wr(4'd10, 8'h0F);
    pin_pulse(6); idle(8);
    rd(4'd10, b); check("R8 capture off with register TOP flag", (b >> 3) & 1, 0);
    rd16(4'd8, v); check("R8 capture off with register TOP value", v, 16'h0ABC);
    wr(4'd0, 8'h00);

    // R9 noise filter width sweep
    wr(4'd1, 8'h18); idle(10);
    for (int w = 1; w <= 6; w++) begin
      wr(4'd10, 8'h0F);
      pin_pulse(w); idle(12);
      rd(4'd10, b); check($sformatf("R9 pulse width %0d", w), (b >> 3) & 1, (w >= 4) ? 1 : 0);
    end

    // R9 filter latency difference
    wr(4'd11, 8'h08);
    flag_latency(8'h08, lat_off);
    flag_latency(8'h18, lat_on);
    check("R9 filter latency", lat_on - lat_off, 4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule